// File: doc/BRIEF.md
# Low-Power Mode Transition Controller

This block holds the operating mode of a small processor core and chooses the next mode whenever the core runs its sleep instruction or a wake-up event arrives. There are seven modes: two full-clock modes (high-speed and medium-speed), a low-clock mode that runs the CPU from the subclock (sub-active), and four halted modes (sleep, sub-sleep, software standby and watch). From the mode it derives the main-clock enable, the subclock enable and the CPU clock gate. It also presents the clock multiplier setting and the noise-filter sampling divider.

Software sets the policy through one 8-bit configuration register, written with a one-cycle strobe. The controller sees the sleep instruction as a one-cycle pulse. It sees two wake inputs: a general interrupt/wake event and an enabled external interrupt. Modes are encoded as high-speed 0, medium-speed 1, sub-active 2, sleep 3, sub-sleep 4, software standby 5 and watch 6.

Top module: `pwrModeSequencer`

## Requirements
- R1: After reset the mode is high-speed (0). The multiplier selection is 0, the subclock is enabled, the noise divider is 32, and the main clock and CPU clock are both enabled.
- R2: With direct transfer (config bit 1) and standby select (config bit 2) both clear, a sleep pulse in high-speed or medium-speed mode enters sleep (3). A wake event or external interrupt then returns the block to the mode it slept from.
- R3: With standby select set and direct transfer clear, a sleep pulse in high-speed mode enters watch (6) if low-speed (config bit 0) is set or the subclock runs (subclock-stop, config bit 3, clear). Otherwise it enters software standby (5). From medium-speed mode a sleep pulse never reaches watch or sub-active; it takes software standby instead.
- R4: With direct transfer set, a sleep pulse in high-speed mode moves straight to sub-active (2), and a sleep pulse in sub-active mode moves straight to high-speed.
- R5: With direct transfer clear, a sleep pulse in sub-active mode enters sub-sleep (4) if standby select is clear and watch if it is set. Any wake input ends sub-sleep in sub-active mode.
- R6: Any wake input ends watch mode. The block resumes in sub-active mode if low-speed is set and in high-speed mode if it is clear.
- R7: Software standby ignores the general wake event and further sleep pulses. It ends only on the external interrupt, and it then resumes in high-speed mode.
- R8: The multiplier field (config bits 7:6) selects 0 = x1, 1 = x2, 2 = x4. A write carrying code 3 leaves the multiplier at its previous value and still updates the other fields.
- R9: The subclock enable output is the inverse of subclock-stop. The noise-sampling select (config bit 4) sets the divider output to 4 when 1 and to 32 when 0.
- R10: The main-clock enable is low in sub-active, sub-sleep, software standby and watch. The CPU clock enable is low in sleep, sub-sleep, software standby and watch.
- R11: Medium-speed request (config bit 5) moves high-speed to medium-speed one cycle after it is seen set. Clearing it returns medium-speed to high-speed.
- R12: A sleep pulse decides with the register contents from before any write in the same cycle. Sleep pulses are ignored while the mode is halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 8 | Configuration write value |
| sleepExec | input | 1 | One-cycle pulse: sleep instruction executed |
| wakeEvent | input | 1 | General interrupt or wake event |
| extIrqWake | input | 1 | Enabled external interrupt |
| modeCode | output | 3 | Current mode encoding |
| mainClkEn | output | 1 | Main oscillator clock enable |
| subClkEn | output | 1 | Subclock generation enable |
| cpuClkEn | output | 1 | CPU clock gate |
| multSel | output | 2 | Active clock multiplier code |
| noiseDiv | output | 6 | Noise-filter sampling divider |

## Verification
A configuration write and a sleep pulse can arrive in the same cycle, and the mode decision then has to use the old register contents. The bench provokes this from high-speed mode with all bits clear: a single cycle carries the sleep pulse together with a write that sets direct transfer. The bench expects sleep, not sub-active. After waking, a second sleep pulse must now take the direct path, which shows that the write did land.

// File: rtl/lpmPkg.sv
package lpmPkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_HIGH     = 3'd0,
    MODE_MEDIUM   = 3'd1,
    MODE_SUBACT   = 3'd2,
    MODE_SLEEP    = 3'd3,
    MODE_SUBSLEEP = 3'd4,
    MODE_SWSTBY   = 3'd5,
    MODE_WATCH    = 3'd6
  } pwrMode_t;

  typedef struct packed {
    logic lowSpeed;
    logic directXfer;
    logic standbySel;
    logic subStop;
    logic noiseFast;
    logic mediumReq;
  } cfgView_t;

  typedef struct packed {
    logic saveOrigin;
    logic originMedium;
  } ctrlStrobe_t;

  function automatic logic isHalted(pwrMode_t m);
    return (m == MODE_SLEEP) || (m == MODE_SUBSLEEP) ||
           (m == MODE_SWSTBY) || (m == MODE_WATCH);
  endfunction
endpackage

// File: rtl/lpmCfgPath.sv
module lpmCfgPath
  import lpmPkg::*;
#(
  parameter int CFG_W    = 8,
  parameter int MULT_W   = 2,
  parameter int NOISE_W  = 6,
  parameter int DIV_SLOW = 32,
  parameter int DIV_FAST = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [CFG_W-1:0]   wrData,
  input  ctrlStrobe_t        strobe,
  output cfgView_t           cfg,
  output logic               originMedium,
  output logic [MULT_W-1:0]  multSel,
  output logic [NOISE_W-1:0] noiseDiv,
  output logic               subClkEn
);
  localparam int MULT_LSB = CFG_W - MULT_W;
  localparam logic [MULT_W-1:0] MULT_RESERVED = '1;

  cfgView_t          cfgQ;
  logic [MULT_W-1:0] multQ;
  logic              originQ;
  logic [MULT_W-1:0] multIn;

  assign multIn = wrData[MULT_LSB +: MULT_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ  <= '0;
      multQ <= '0;
    end else if (wrEn) begin
      cfgQ.lowSpeed   <= wrData[0];
      cfgQ.directXfer <= wrData[1];
      cfgQ.standbySel <= wrData[2];
      cfgQ.subStop    <= wrData[3];
      cfgQ.noiseFast  <= wrData[4];
      cfgQ.mediumReq  <= wrData[5];
      if (multIn != MULT_RESERVED) multQ <= multIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) originQ <= 1'b0;
    else if (strobe.saveOrigin) originQ <= strobe.originMedium;
  end

  assign cfg          = cfgQ;
  assign originMedium = originQ;
  assign multSel      = multQ;
  assign subClkEn     = ~cfgQ.subStop;
  assign noiseDiv     = cfgQ.noiseFast ? NOISE_W'(DIV_FAST) : NOISE_W'(DIV_SLOW);

  assert_mult_reserved_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && multIn == MULT_RESERVED) |=> $stable(multSel));

  assert_mult_legal_R8: assert property (@(posedge clk) disable iff (!rstN)
    multSel != MULT_RESERVED);
endmodule

// File: rtl/lpmModeFsm.sv
module lpmModeFsm
  import lpmPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sleepExec,
  input  logic        wakeEvent,
  input  logic        extIrqWake,
  input  cfgView_t    cfg,
  input  logic        originMedium,
  output pwrMode_t    mode,
  output ctrlStrobe_t strobe,
  output logic        mainClkEn,
  output logic        cpuClkEn
);
  pwrMode_t modeQ, modeD;
  logic     anyWake;

  assign anyWake = wakeEvent | extIrqWake;

  always_comb begin
    modeD  = modeQ;
    strobe = '0;
    unique case (modeQ)
      MODE_HIGH, MODE_MEDIUM: begin
        if (sleepExec) begin
          if (cfg.directXfer && modeQ == MODE_HIGH) begin
            modeD = MODE_SUBACT;
          end else if (!cfg.standbySel) begin
            modeD               = MODE_SLEEP;
            strobe.saveOrigin   = 1'b1;
            strobe.originMedium = (modeQ == MODE_MEDIUM);
          end else if (modeQ == MODE_HIGH && (cfg.lowSpeed || !cfg.subStop)) begin
            modeD = MODE_WATCH;
          end else begin
            modeD = MODE_SWSTBY;
          end
        end else if (modeQ == MODE_HIGH && cfg.mediumReq) begin
          modeD = MODE_MEDIUM;
        end else if (modeQ == MODE_MEDIUM && !cfg.mediumReq) begin
          modeD = MODE_HIGH;
        end
      end
      MODE_SUBACT: begin
        if (sleepExec) begin
          if (cfg.directXfer)      modeD = MODE_HIGH;
          else if (cfg.standbySel) modeD = MODE_WATCH;
          else                     modeD = MODE_SUBSLEEP;
        end
      end
      MODE_SLEEP:    if (anyWake) modeD = originMedium ? MODE_MEDIUM : MODE_HIGH;
      MODE_SUBSLEEP: if (anyWake) modeD = MODE_SUBACT;
      MODE_WATCH:    if (anyWake) modeD = cfg.lowSpeed ? MODE_SUBACT : MODE_HIGH;
      MODE_SWSTBY:   if (extIrqWake) modeD = MODE_HIGH;
      default:       modeD = MODE_HIGH;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeQ <= MODE_HIGH;
    else       modeQ <= modeD;
  end

  assign mode      = modeQ;
  assign cpuClkEn  = ~isHalted(modeQ);
  assign mainClkEn = ~((modeQ == MODE_SUBACT) || (modeQ == MODE_SUBSLEEP) ||
                       (modeQ == MODE_SWSTBY) || (modeQ == MODE_WATCH));

  assert_medium_no_low_path_R3: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_MEDIUM && sleepExec) |=> (modeQ != MODE_WATCH && modeQ != MODE_SUBACT));

  assert_stby_holds_R7: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_SWSTBY && !extIrqWake) |=> (modeQ == MODE_SWSTBY));

  assert_subsleep_wake_R5: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_SUBSLEEP && anyWake) |=> (modeQ == MODE_SUBACT));

  assert_halted_stable_R12: assert property (@(posedge clk) disable iff (!rstN)
    (isHalted(modeQ) && !anyWake) |=> $stable(modeQ));

  assert_direct_hop_R4: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_SUBACT && sleepExec && cfg.directXfer) |=> (modeQ == MODE_HIGH));
endmodule

// File: rtl/pwrModeSequencer.sv
module pwrModeSequencer
  import lpmPkg::*;
#(
  parameter int CFG_W   = 8,
  parameter int MULT_W  = 2,
  parameter int NOISE_W = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [CFG_W-1:0]   cfgWrData,
  input  logic               sleepExec,
  input  logic               wakeEvent,
  input  logic               extIrqWake,
  output logic [MODE_W-1:0]  modeCode,
  output logic               mainClkEn,
  output logic               subClkEn,
  output logic               cpuClkEn,
  output logic [MULT_W-1:0]  multSel,
  output logic [NOISE_W-1:0] noiseDiv
);
  cfgView_t    cfg;
  ctrlStrobe_t strobe;
  pwrMode_t    mode;
  logic        originMedium;

  lpmCfgPath #(.CFG_W(CFG_W), .MULT_W(MULT_W), .NOISE_W(NOISE_W)) uPath (
    .clk(clk), .rstN(rstN), .wrEn(cfgWrEn), .wrData(cfgWrData), .strobe(strobe),
    .cfg(cfg), .originMedium(originMedium), .multSel(multSel),
    .noiseDiv(noiseDiv), .subClkEn(subClkEn)
  );

  lpmModeFsm uFsm (
    .clk(clk), .rstN(rstN), .sleepExec(sleepExec), .wakeEvent(wakeEvent),
    .extIrqWake(extIrqWake), .cfg(cfg), .originMedium(originMedium),
    .mode(mode), .strobe(strobe), .mainClkEn(mainClkEn), .cpuClkEn(cpuClkEn)
  );

  assign modeCode = mode;
endmodule

// File: tb/sim_pwrModeSequencer.sv
module sim_pwrModeSequencer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [7:0] cfgWrData = '0;
  logic       sleepExec = 1'b0;
  logic       wakeEvent = 1'b0;
  logic       extIrqWake = 1'b0;
  logic [2:0] modeCode;
  logic       mainClkEn, subClkEn, cpuClkEn;
  logic [1:0] multSel;
  logic [5:0] noiseDiv;

  int vecCount = 0;
  int errCount = 0;

  always #2 clk = ~clk;

  pwrModeSequencer u0 (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .sleepExec(sleepExec), .wakeEvent(wakeEvent), .extIrqWake(extIrqWake),
    .modeCode(modeCode), .mainClkEn(mainClkEn), .subClkEn(subClkEn),
    .cpuClkEn(cpuClkEn), .multSel(multSel), .noiseDiv(noiseDiv)
  );

  task automatic check(string tag, int act, int exp);
    vecCount++;
    if (act != exp) begin
      errCount++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, results visible at the following negedge
  task automatic step(logic sl, logic wk, logic ex, logic we, logic [7:0] wd);
    sleepExec = sl; wakeEvent = wk; extIrqWake = ex; cfgWrEn = we; cfgWrData = wd;
    @(negedge clk);
    sleepExec = 0; wakeEvent = 0; extIrqWake = 0; cfgWrEn = 0; cfgWrData = '0;
  endtask

  task automatic wrCfg(logic [7:0] v); step(0, 0, 0, 1, v); endtask
  task automatic doSleep(); step(1, 0, 0, 0, '0); endtask
  task automatic doWake();  step(0, 1, 0, 0, '0); endtask
  task automatic doExt();   step(0, 0, 1, 0, '0); endtask
  task automatic idle();    step(0, 0, 0, 0, '0); endtask

  task automatic testReset();
    check("R1 mode", modeCode, 0);
    check("R1 mult", multSel, 0);
    check("R1 subclk", subClkEn, 1);
    check("R1 noise", noiseDiv, 32);
    check("R1 main", mainClkEn, 1);
    check("R1 cpu", cpuClkEn, 1);
  endtask

  task automatic testSleepHigh();
    doSleep();
    check("R2 sleep from high", modeCode, 3);
    check("R10 cpu gated in sleep", cpuClkEn, 0);
    check("R10 main on in sleep", mainClkEn, 1);
    doWake();
    check("R2 wake to high", modeCode, 0);
  endtask

  task automatic testMedium();
    wrCfg(8'h20); idle();
    check("R11 enter medium", modeCode, 1);
    doSleep();
    check("R2 sleep from medium", modeCode, 3);
    doWake();
    check("R2 wake to medium", modeCode, 1);
    wrCfg(8'h25); doSleep();
    check("R3 medium takes standby", modeCode, 5);
    doWake();
    check("R7 wake ignored in standby", modeCode, 5);
    doExt();
    check("R7 ext ends standby", modeCode, 0);
    idle();
    check("R11 back to medium", modeCode, 1);
    wrCfg(8'h00); idle();
    check("R11 leave medium", modeCode, 0);
  endtask

  task automatic testWatch();
    wrCfg(8'h04); doSleep();
    check("R3 watch via subclock", modeCode, 6);
    check("R10 main off in watch", mainClkEn, 0);
    check("R10 cpu off in watch", cpuClkEn, 0);
    doWake();
    check("R6 watch exit to high", modeCode, 0);
    wrCfg(8'h05); doSleep();
    check("R3 watch via lowspeed", modeCode, 6);
    doWake();
    check("R6 watch exit to subact", modeCode, 2);
    check("R10 main off in subact", mainClkEn, 0);
    check("R10 cpu on in subact", cpuClkEn, 1);
  endtask

  task automatic testSubActive();
    wrCfg(8'h01); doSleep();
    check("R5 subsleep", modeCode, 4);
    check("R10 cpu off in subsleep", cpuClkEn, 0);
    doSleep();
    check("R12 sleep ignored when halted", modeCode, 4);
    doWake();
    check("R5 subsleep wake", modeCode, 2);
    wrCfg(8'h05); doSleep();
    check("R5 subact to watch", modeCode, 6);
    doExt();
    check("R6 ext ends watch", modeCode, 2);
    wrCfg(8'h03); doSleep();
    check("R4 direct subact to high", modeCode, 0);
    check("R10 main on in high", mainClkEn, 1);
  endtask

  task automatic testDirect();
    doSleep();
    check("R4 direct high to subact", modeCode, 2);
    doSleep();
    check("R4 direct back to high", modeCode, 0);
    wrCfg(8'h00);
  endtask

  task automatic testStandby();
    wrCfg(8'h0C);
    check("R9 subclock disabled", subClkEn, 0);
    doSleep();
    check("R3 standby when subclock stopped", modeCode, 5);
    doWake();
    check("R7 wake ignored", modeCode, 5);
    doSleep();
    check("R7 sleep ignored", modeCode, 5);
    doExt();
    check("R7 resume high", modeCode, 0);
    wrCfg(8'h00);
    check("R9 subclock enabled", subClkEn, 1);
  endtask

  task automatic testMult();
    wrCfg(8'h40);
    check("R8 mult x2", multSel, 1);
    wrCfg(8'hD0);
    check("R8 reserved keeps mult", multSel, 1);
    check("R9 noise fast", noiseDiv, 4);
    wrCfg(8'h80);
    check("R8 mult x4", multSel, 2);
    check("R9 noise slow", noiseDiv, 32);
    wrCfg(8'h00);
    check("R8 mult x1", multSel, 0);
  endtask

  task automatic testSameCycle();
    step(1, 0, 0, 1, 8'h02);
    check("R12 old cfg decides", modeCode, 3);
    doWake();
    check("R12 wake", modeCode, 0);
    doSleep();
    check("R12 new cfg applied", modeCode, 2);
    doSleep();
    check("R12 back high", modeCode, 0);
    wrCfg(8'h00);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rstN = 1'b1;
        @(negedge clk);
        testReset();
        testSleepHigh();
        testMedium();
        testWatch();
        testSubActive();
        testDirect();
        testStandby();
        testMult();
        testSameCycle();
      end
      begin
        repeat (5000) @(negedge clk);
        errCount++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end
endmodule